// File: doc/BRIEF.md
# Programmable Memory Transfer Sequencer

This block orders the macroblock data movements inside a memory-interface controller. A short program of 20-bit instructions sits in a 64-word local instruction store. The program decides, for each step, which on-chip module port supplies the data, which one receives it, and how long the burst is. One side of a step may be external memory. A step can also pass data straight from one module to another, and then external memory is not touched at all.

While a transfer step runs, the sequencer holds request strobes on the selected ports and stalls until a completion status returns. A wait step parks the program until the next macroblock boundary. Together with a jump back to the loop head, this lets software space transfers out over time. For example, it can leave coarse motion results in memory until the refinement stage is ready to fetch them.

The host loads the program through a simple write port, which only works while the sequencer is halted. A start pulse then runs the program from word 0.

Top module: `xfer_seq`

## Requirements
- R1: After reset the sequencer is halted: busy=0, pc=0, mem_req=0, mem_wr=0, port_req=0, burst_len=0, burst_flags=0.
- R2: A go pulse while halted starts execution at word 0: in the next cycle busy=1 and pc=0.
- R3: Instruction layout is op[19:17], src[16:13], dst[12:9], len[8:2], flags[1:0]; id 0 is external memory and ids 1..15 are module ports (bit i of port_req belongs to id i). Opcode 1 (memory move) with exactly one side equal to 0 enters a transfer one cycle after it is fetched. In the transfer it drives mem_req=1, mem_wr=1 when dst is 0 (else 0), port_req one-hot on the non-memory id, burst_len=len and burst_flags=flags. These stay steady until a cycle with xfer_done=1, after which pc advances by one and the strobes drop.
- R4: Opcode 2 (relay) with two nonzero, different ids drives mem_req=0 with the port_req bits of both src and dst set for every cycle until xfer_done, and then advances pc.
- R5: A move whose sides are both memory or both ports, or a relay that names memory or the same id twice, is skipped: no strobe is driven and pc advances after one cycle.
- R6: Opcode 3 (wait for macroblock) stalls with no strobes while mb_start=0 and advances pc in the cycle after mb_start=1.
- R7: Opcode 4 (jump) loads pc from instruction bits [5:0] one cycle after fetch.
- R8: Opcode 0 and the unused opcodes 5..7 halt the sequencer: busy=0 in the next cycle with pc kept.
- R9: A host write changes the instruction store only when the sequencer is halted; a write in any busy cycle, including the cycle that executes a halt, is dropped.
- R10: pc advancing past word 63 wraps to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, honoured when halted |
| mb_start | input | 1 | Macroblock boundary pulse |
| xfer_done | input | 1 | Completion status for the active transfer |
| host_we | input | 1 | Instruction store write enable |
| host_addr | input | 6 | Instruction store write address |
| host_wdata | input | 20 | Instruction word to write |
| busy | output | 1 | Sequencer is running (not halted) |
| pc | output | 6 | Program counter |
| mem_req | output | 1 | External memory access request |
| mem_wr | output | 1 | Memory access direction, 1 = write into memory |
| port_req | output | 16 | Per-module request strobes, bit per id |
| burst_len | output | 7 | Burst length of the active transfer |
| burst_flags | output | 2 | Flag bits of the active transfer |

## Verification
The risky overlap is a host write landing in the same cycle that the program executes its halt: the store must still reject it, because the sequencer only counts as halted from the next cycle. The bench holds the write enable high across a whole run, aimed at a word the program later executes. It drops the enable only once busy is seen low, then jumps to that word in a later run. A behavioural model compares every output each cycle, so an accepted write shows up as strobes where the model expects none.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  localparam int IW   = 20;            // instruction width
  localparam int AW   = 6;             // instruction address width
  localparam int OPW  = 3;
  localparam int IDW  = 4;
  localparam int LW   = 7;
  localparam int FW   = 2;
  localparam int NPORT = 1 << IDW;
  localparam logic [IDW-1:0] MEM_ID = '0;

  localparam logic [OPW-1:0] OP_HALT  = 3'd0;
  localparam logic [OPW-1:0] OP_MOVE  = 3'd1;
  localparam logic [OPW-1:0] OP_RELAY = 3'd2;
  localparam logic [OPW-1:0] OP_WAIT  = 3'd3;
  localparam logic [OPW-1:0] OP_JUMP  = 3'd4;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [IDW-1:0] src;
    logic [IDW-1:0] dst;
    logic [LW-1:0]  len;
    logic [FW-1:0]  flg;
  } insn_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_XFER, ST_WAIT} seq_st_e;

  function automatic logic [NPORT-1:0] id_strobe(logic [IDW-1:0] id);
    return NPORT'(1) << id;
  endfunction

  function automatic logic [AW-1:0] jump_target(insn_t ins);
    return AW'({ins.len, ins.flg});
  endfunction
endpackage

// File: rtl/xfer_imem.sv
module xfer_imem #(
  parameter int AW = 6,
  parameter int IW = 20
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [IW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_seq_pkg::*;
(
  input  insn_t            ins,
  output logic             is_xfer,
  output logic             is_legal,
  output logic             is_wait,
  output logic             is_jump,
  output logic             to_mem,
  output logic             uses_mem,
  output logic [NPORT-1:0] mask
);
  logic src_mem, dst_mem;

  always_comb begin
    src_mem  = (ins.src == MEM_ID);
    dst_mem  = (ins.dst == MEM_ID);
    is_xfer  = 1'b0;
    is_legal = 1'b0;
    is_wait  = 1'b0;
    is_jump  = 1'b0;
    uses_mem = 1'b0;
    to_mem   = 1'b0;
    mask     = '0;
    case (ins.op)
      OP_MOVE: begin
        is_xfer  = 1'b1;
        is_legal = src_mem ^ dst_mem;
        uses_mem = 1'b1;
        to_mem   = dst_mem;
        mask     = id_strobe(dst_mem ? ins.src : ins.dst);
      end
      OP_RELAY: begin
        is_xfer  = 1'b1;
        is_legal = !src_mem && !dst_mem && (ins.src != ins.dst);
        mask     = id_strobe(ins.src) | id_strobe(ins.dst);
      end
      OP_WAIT: is_wait = 1'b1;
      OP_JUMP: is_jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             mb_start,
  input  logic             xfer_done,
  input  insn_t            ins,
  input  logic             d_xfer,
  input  logic             d_legal,
  input  logic             d_wait,
  input  logic             d_jump,
  input  logic             d_to_mem,
  input  logic             d_uses_mem,
  input  logic [NPORT-1:0] d_mask,
  output logic [AW-1:0]    pc,
  output logic             busy,
  output logic             waiting,
  output logic             mem_req,
  output logic             mem_wr,
  output logic [NPORT-1:0] port_req,
  output logic [LW-1:0]    burst_len,
  output logic [FW-1:0]    burst_flags
);
  seq_st_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; pc <= '0;
      mem_req <= 1'b0; mem_wr <= 1'b0; port_req <= '0;
      burst_len <= '0; burst_flags <= '0;
    end else begin
      case (st)
        ST_IDLE: if (go) begin st <= ST_RUN; pc <= '0; end
        ST_RUN: begin
          if (d_xfer && d_legal) begin
            st <= ST_XFER;
            mem_req <= d_uses_mem; mem_wr <= d_to_mem; port_req <= d_mask;
            burst_len <= ins.len; burst_flags <= ins.flg;
          end else if (d_xfer)  pc <= pc + 1'b1;
          else if (d_wait)      st <= ST_WAIT;
          else if (d_jump)      pc <= jump_target(ins);
          else                  st <= ST_IDLE;
        end
        ST_XFER: if (xfer_done) begin
          st <= ST_RUN; pc <= pc + 1'b1;
          mem_req <= 1'b0; mem_wr <= 1'b0; port_req <= '0;
          burst_len <= '0; burst_flags <= '0;
        end
        ST_WAIT: if (mb_start) begin st <= ST_RUN; pc <= pc + 1'b1; end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign waiting = (st == ST_WAIT);
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             mb_start,
  input  logic             xfer_done,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [IW-1:0]    host_wdata,
  output logic             busy,
  output logic [AW-1:0]    pc,
  output logic             mem_req,
  output logic             mem_wr,
  output logic [NPORT-1:0] port_req,
  output logic [LW-1:0]    burst_len,
  output logic [FW-1:0]    burst_flags
);
  logic [IW-1:0]    word;
  insn_t            ins;
  logic             d_xfer, d_legal, d_wait, d_jump, d_to_mem, d_uses_mem;
  logic [NPORT-1:0] d_mask;
  logic             waiting;
  logic             imem_we;

  // writes are only taken while halted (R9)
  assign imem_we = host_we && !busy;
  assign ins     = insn_t'(word);

  xfer_imem #(.AW(AW), .IW(IW)) u_imem (
    .clk(clk), .we(imem_we), .waddr(host_addr), .wdata(host_wdata),
    .raddr(pc), .rdata(word)
  );

  xfer_decode u_dec (
    .ins(ins), .is_xfer(d_xfer), .is_legal(d_legal), .is_wait(d_wait),
    .is_jump(d_jump), .to_mem(d_to_mem), .uses_mem(d_uses_mem), .mask(d_mask)
  );

  xfer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .mb_start(mb_start), .xfer_done(xfer_done),
    .ins(ins), .d_xfer(d_xfer), .d_legal(d_legal), .d_wait(d_wait), .d_jump(d_jump),
    .d_to_mem(d_to_mem), .d_uses_mem(d_uses_mem), .d_mask(d_mask),
    .pc(pc), .busy(busy), .waiting(waiting), .mem_req(mem_req), .mem_wr(mem_wr),
    .port_req(port_req), .burst_len(burst_len), .burst_flags(burst_flags)
  );
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk
  import xfer_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             mb_start,
  input logic             xfer_done,
  input logic             busy,
  input logic             waiting,
  input logic             imem_we,
  input logic [AW-1:0]    pc,
  input logic             mem_req,
  input logic [NPORT-1:0] port_req
);
  AST_GO_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go) |=> (busy && pc == '0)); // R2
  AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || port_req != '0) |-> busy); // R3
  AST_MOVE_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(port_req) == 1)); // R3
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_req || port_req != '0) && !xfer_done) |=>
      ($stable(port_req) && $stable(mem_req) && $stable(pc))); // R3
  AST_RELAY_TWO_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && port_req != '0) |-> ($countones(port_req) == 2)); // R4
  AST_WAIT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !mb_start) |=> ($stable(pc) && port_req == '0 && !mem_req)); // R6
  AST_WRITE_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    imem_we |-> !busy); // R9
endmodule

bind xfer_seq xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .mb_start(mb_start), .xfer_done(xfer_done),
  .busy(busy), .waiting(waiting), .imem_we(imem_we), .pc(pc),
  .mem_req(mem_req), .port_req(port_req)
);

// File: tb/xfer_seq_bench.sv
module xfer_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0, mb_start = 1'b0, xfer_done = 1'b0, host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [19:0] host_wdata = '0;
  logic        busy, mem_req, mem_wr;
  logic [5:0]  pc;
  logic [15:0] port_req;
  logic [6:0]  burst_len;
  logic [1:0]  burst_flags;

  int compared = 0, mismatched = 0, cycles = 0;
  string tag = "R1";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_seq u_xfer_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .mb_start(mb_start), .xfer_done(xfer_done),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .busy(busy), .pc(pc), .mem_req(mem_req), .mem_wr(mem_wr), .port_req(port_req),
    .burst_len(burst_len), .burst_flags(burst_flags)
  );

  // behavioural reference: 0 halted, 1 fetch, 2 transfer, 3 macroblock wait
  int m_st = 0, m_pc = 0, m_word = 0;
  int m_mem [64];

  function automatic int mk(int op, int s, int d, int len, int f);
    return op * 131072 + s * 8192 + d * 512 + len * 4 + f;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_pc = 0;
    end else if (m_st == 0) begin
      if (host_we) m_mem[host_addr] = host_wdata;
      if (go) begin m_st = 1; m_pc = 0; end
    end else if (m_st == 1) begin
      int w, op, s, d;
      w = m_mem[m_pc]; op = w / 131072; s = (w / 8192) % 16; d = (w / 512) % 16;
      if (op == 1) begin
        if ((s == 0) != (d == 0)) begin m_st = 2; m_word = w; end
        else m_pc = (m_pc + 1) % 64;
      end else if (op == 2) begin
        if (s != 0 && d != 0 && s != d) begin m_st = 2; m_word = w; end
        else m_pc = (m_pc + 1) % 64;
      end else if (op == 3) m_st = 3;
      else if (op == 4) m_pc = w % 64;
      else m_st = 0;
    end else if (m_st == 2) begin
      if (xfer_done) begin m_st = 1; m_pc = (m_pc + 1) % 64; end
    end else begin
      if (mb_start) begin m_st = 1; m_pc = (m_pc + 1) % 64; end
    end
  end

  task automatic compare_all();
    int e_req, e_wr, e_ports, e_len, e_flg, op, s, d;
    e_req = 0; e_wr = 0; e_ports = 0; e_len = 0; e_flg = 0;
    if (m_st == 2) begin
      op = m_word / 131072; s = (m_word / 8192) % 16; d = (m_word / 512) % 16;
      e_len = (m_word / 4) % 128; e_flg = m_word % 4;
      if (op == 1) begin
        e_req = 1; e_wr = (d == 0);
        e_ports = 1 << ((d == 0) ? s : d);
      end else e_ports = (1 << s) | (1 << d);
    end
    compared++;
    if (busy !== (m_st != 0) || pc !== m_pc[5:0] || mem_req !== e_req[0] ||
        mem_wr !== e_wr[0] || port_req !== e_ports[15:0] ||
        burst_len !== e_len[6:0] || burst_flags !== e_flg[1:0]) begin
      mismatched++;
      $display("FAIL %s: busy=%0d pc=%0d req=%0d wr=%0d ports=%h len=%0d flg=%0d expected busy=%0d pc=%0d req=%0d wr=%0d ports=%h len=%0d flg=%0d",
               tag, busy, pc, mem_req, mem_wr, port_req, burst_len, burst_flags,
               (m_st != 0), m_pc, e_req, e_wr, e_ports, e_len, e_flg);
    end
  endtask

  always @(negedge clk) if (!finished) compare_all();

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      summary();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int w);
    host_we = 1; host_addr = a[5:0]; host_wdata = w[19:0]; tick(); host_we = 0;
  endtask

  task automatic pulse_go();     go = 1; tick(); go = 0; endtask
  task automatic pulse_mb();     mb_start = 1; tick(); mb_start = 0; endtask
  task automatic pulse_done();   xfer_done = 1; tick(); xfer_done = 0; endtask

  task automatic wait_halt();
    for (int k = 0; k < 40 && busy; k++) tick();
  endtask

  task automatic run_body();
    tag = "R6"; tick(3); pulse_mb();          // word 0 waits for macroblock
    tag = "R3"; tick(4); pulse_done();        // word 1 memory to port 3
    tag = "R3"; tick(2); pulse_done();        // word 2 port 5 to memory
    tag = "R4"; tick(1); pulse_done();        // word 3 relay 2 -> 7
    tag = "R5"; tick(3);                      // words 4,5 skipped
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tag = "R1"; tick(2);
    for (int i = 0; i < 64; i++) wr(i, mk(0, 0, 0, 0, 0));
    wr(0, mk(3, 0, 0, 0, 0));
    wr(1, mk(1, 0, 3, 16, 1));
    wr(2, mk(1, 5, 0, 64, 2));
    wr(3, mk(2, 2, 7, 127, 3));
    wr(4, mk(1, 4, 6, 9, 0));
    wr(5, mk(2, 0, 3, 9, 0));
    wr(6, mk(4, 0, 0, 0, 0) + 8);
    wr(7, mk(0, 0, 0, 0, 0));
    wr(8, mk(5, 1, 2, 3, 0));
    // run A: write aimed at word 7 held across the whole run, including the halt cycle
    tag = "R2"; pulse_go();
    host_we = 1; host_addr = 6'd7; host_wdata = 20'(mk(1, 0, 9, 5, 1));
    run_body();
    tag = "R8"; wait_halt(); host_we = 0; tick();
    // run B: jump into word 7, which must still halt
    tag = "R9"; wr(8, mk(4, 0, 0, 0, 0) + 7);
    tag = "R2"; pulse_go(); run_body();
    tag = "R9"; wait_halt(); tick(2);
    // run C: walk off the top of the store
    wr(7, mk(4, 0, 0, 0, 0) + 62);
    wr(62, mk(1, 0, 0, 4, 0));
    wr(63, mk(2, 4, 4, 4, 0));
    tag = "R7"; pulse_go(); run_body();
    tag = "R10"; tick(8);
    compared++;
    if (!(busy === 1'b1 && pc === 6'd0)) begin
      mismatched++;
      $display("FAIL R10: busy=%0d pc=%0d expected busy=1 pc=0", busy, pc);
    end
    summary();
  end
endmodule